// File: doc/BRIEF.md
# Serial PCM Port with Automatic Frame-Format Detection

This block moves one PCM word each frame between a serial line and the parallel side of a voice codec. The serial side is timed by an external bit clock and two frame syncs, one per direction. Both are sampled by a faster system clock, and the block acts on the rising and falling bit-clock edges it detects. The transmit side shifts a word out, sign bit first. It raises a drive-enable and pulls an active-low slot indicator while it owns the line. The receive side assembles a word from the serial data and hands it over together with a one-cycle valid strobe.

The framing convention is not configured. It is measured from the sync pulses. A pulse that spans one bit-clock falling edge selects short-frame timing. A pulse that spans two or more falling edges selects long-frame timing. The transmit sync decides the format. The receive sync decides it only after the transmit sync has been missing for a programmable number of bit clocks. A new format applies to frames that begin after the measuring pulse has ended.

Top module: `pcm_serial_port`

## Requirements
- R1: After reset the format is short (frame_long_o = 0). When a deciding sync pulse ends, the format becomes short if exactly one bit-clock falling edge occurred while the sync was high, and long if two or more did. A pulse with no falling edge inside it changes nothing.
- R2: Long format, transmit. The frame starts in the first cycle in which the transmit sync and the bit clock are both high. The drive-enable then turns on and tx_data_o shows word bit 7, the sign bit.
- R3: Long format, transmit. The next WORD_W-1 rising bit-clock edges present bits 6 down to 0. The drive turns off on whichever comes later: the 8th falling edge after the start, or the fall of the transmit sync.
- R4: Long format. If the transmit sync stays high past eight bit periods, the drive stays on and holds bit 0 until the sync falls.
- R5: Short format, transmit. A falling bit-clock edge that finds the transmit sync high arms the frame. The next rising edge turns the drive on with bit 7. Bits 6..0 follow on the following rising edges. The drive turns off on the 8th falling edge after the start, whatever the sync does.
- R6: Long format, receive. After a rising receive sync, the next eight falling bit-clock edges capture rx_data_i, most significant bit first.
- R7: Short format, receive. The first falling edge after the receive sync rises is skipped. The sign bit is captured on the second falling edge, and the next seven falling edges capture bits 6..0.
- R8: tx_slot_n_o is low exactly while tx_drive_o is high. tx_data_o is 0 whenever the drive is off.
- R9: The receive sync width is ignored while the transmit sync is present. After ABSENT_BITS rising bit-clock edges with the transmit sync low, the receive sync width decides the format, and the transmit drive stays off.
- R10: Each completed receive word appears on rx_word_o with rx_valid_o high for exactly one clock, once per frame. The transmit word is sampled from tx_word_i when the frame starts, so later changes to tx_word_i do not affect that frame.
- R11: During and right after reset, the drive is off, the slot indicator is high and rx_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial inputs |
| rst | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | Serial bit clock |
| tx_sync_i | input | 1 | Transmit frame sync |
| rx_sync_i | input | 1 | Receive frame sync |
| rx_data_i | input | 1 | Serial receive data |
| tx_word_i | input | WORD_W | Parallel word to transmit, bit WORD_W-1 is the sign |
| tx_data_o | output | 1 | Serial transmit data |
| tx_drive_o | output | 1 | High while the transmit line is driven |
| tx_slot_n_o | output | 1 | Active-low time-slot indicator |
| rx_word_o | output | WORD_W | Last completed receive word |
| rx_valid_o | output | 1 | One-clock strobe when rx_word_o updates |
| frame_long_o | output | 1 | Current format: 1 long, 0 short |

## Verification
The bench builds the block with WORD_W = 8 and ABSENT_BITS = 40. At that setting the transmit sync counts as lost after under three 16-bit frames, so the hand-over of format control to the receive sync can be reached in a short run. The bit clock is eight system clocks per period, which leaves room to sample each high and low phase after its edge. The frame lengths chosen cover long syncs of three and eleven bit periods, the hold-until-sync-falls case and a word change in the middle of a frame.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

    typedef enum logic {
        FMT_SHORT = 1'b0,
        FMT_LONG  = 1'b1
    } frame_fmt_e;

    // Result of one sync-width measurement
    typedef struct packed {
        logic       done;
        frame_fmt_e fmt;
    } width_res_t;

    // Two or more falling bit-clock edges inside a sync pulse mean long frame
    function automatic frame_fmt_e falls_to_fmt(input logic [1:0] falls);
        return (falls >= 2'd2) ? FMT_LONG : FMT_SHORT;
    endfunction

endpackage

// File: rtl/pcm_edge_sense.sv
module pcm_edge_sense (
    input  logic clk,
    input  logic rst,
    input  logic bclk_i,
    output logic rise_o,
    output logic fall_o
);
    logic bclk_q;

    always_ff @(posedge clk) begin
        if (rst) bclk_q <= 1'b0;
        else     bclk_q <= bclk_i;
    end

    assign rise_o = bclk_i & ~bclk_q;
    assign fall_o = ~bclk_i & bclk_q;
endmodule

// File: rtl/pcm_width_meter.sv
module pcm_width_meter
    import pcm_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sync_i,
    input  logic       fall_i,
    output width_res_t res_o
);
    logic       sync_q;
    logic [1:0] falls;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 1'b0;
            falls  <= '0;
            res_o  <= '{done: 1'b0, fmt: FMT_SHORT};
        end else begin
            sync_q     <= sync_i;
            res_o.done <= 1'b0;
            if (sync_i && fall_i && falls != 2'd3)
                falls <= falls + 2'd1;
            if (sync_q && !sync_i) begin
                res_o.done <= (falls != 2'd0);
                res_o.fmt  <= falls_to_fmt(falls);
                falls      <= '0;
            end
        end
    end

    p_done_on_sync_fall_r1: assert property (@(posedge clk) disable iff (rst)
        res_o.done |-> !$past(sync_i));
endmodule

// File: rtl/pcm_tx_slot.sv
module pcm_tx_slot
    import pcm_port_pkg::*;
#(
    parameter int unsigned WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_i,
    input  logic              bclk_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  frame_fmt_e        fmt_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              data_o,
    output logic              drive_o
);
    localparam int unsigned CW = $clog2(WORD_W + 1);
    localparam logic [CW-1:0] LAST_SHIFT = CW'(WORD_W - 1);
    localparam logic [CW-1:0] ALL_FALLS  = CW'(WORD_W);

    logic              active, pending, armed;
    frame_fmt_e        fmt_q;
    logic [WORD_W-1:0] sr;
    logic [CW-1:0]     rises, falls;
    logic              reach_end, release_now;

    assign reach_end   = (falls == ALL_FALLS) || (fall_i && falls == LAST_SHIFT);
    assign release_now = reach_end && (fmt_q == FMT_SHORT || !sync_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            pending <= 1'b0;
            armed   <= 1'b0;
            fmt_q   <= FMT_SHORT;
            sr      <= '0;
            rises   <= '0;
            falls   <= '0;
        end else begin
            if (!sync_i) armed <= 1'b1;
            if (!active) begin
                if (pending && rise_i) begin
                    active  <= 1'b1;
                    pending <= 1'b0;
                    fmt_q   <= FMT_SHORT;
                    sr      <= word_i;
                    rises   <= '0;
                    falls   <= '0;
                end else if (fmt_i == FMT_LONG && armed && sync_i && bclk_i) begin
                    active <= 1'b1;
                    armed  <= 1'b0;
                    fmt_q  <= FMT_LONG;
                    sr     <= word_i;
                    rises  <= '0;
                    falls  <= '0;
                end else if (fmt_i == FMT_SHORT && armed && sync_i && fall_i) begin
                    pending <= 1'b1;
                    armed   <= 1'b0;
                end
            end else begin
                if (rise_i && rises < LAST_SHIFT) begin
                    sr    <= {sr[WORD_W-2:0], 1'b0};
                    rises <= rises + 1'b1;
                end
                if (fall_i && falls < ALL_FALLS)
                    falls <= falls + 1'b1;
                if (release_now)
                    active <= 1'b0;
            end
        end
    end

    assign drive_o = active;
    assign data_o  = active & sr[WORD_W-1];

    p_long_start_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(active) && fmt_q == FMT_LONG |-> $past(sync_i && bclk_i));
    p_hold_while_sync_r4: assert property (@(posedge clk) disable iff (rst)
        active && fmt_q == FMT_LONG && sync_i |=> active);
    p_short_release_edge_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(active) && fmt_q == FMT_SHORT |-> $past(fall_i));
endmodule

// File: rtl/pcm_rx_slot.sv
module pcm_rx_slot
    import pcm_port_pkg::*;
#(
    parameter int unsigned WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_i,
    input  logic              fall_i,
    input  logic              data_i,
    input  frame_fmt_e        fmt_i,
    output logic [WORD_W-1:0] word_o,
    output logic              valid_o
);
    localparam int unsigned CW = $clog2(WORD_W + 1);
    localparam logic [CW-1:0] LAST_BIT = CW'(WORD_W - 1);

    logic              sync_q, active, skip;
    logic [CW-1:0]     cnt;
    logic [WORD_W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= 1'b0;
            active  <= 1'b0;
            skip    <= 1'b0;
            cnt     <= '0;
            sr      <= '0;
            word_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            sync_q  <= sync_i;
            valid_o <= 1'b0;
            if (!active) begin
                if (sync_i && !sync_q) begin
                    active <= 1'b1;
                    skip   <= (fmt_i == FMT_SHORT);
                    cnt    <= '0;
                end
            end else if (fall_i) begin
                if (skip) begin
                    skip <= 1'b0;
                end else begin
                    sr <= {sr[WORD_W-2:0], data_i};
                    if (cnt == LAST_BIT) begin
                        active  <= 1'b0;
                        word_o  <= {sr[WORD_W-2:0], data_i};
                        valid_o <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            end
        end
    end

    p_valid_one_cycle_r10: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);
    p_valid_after_fall_r6: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> $past(fall_i));
endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port
    import pcm_port_pkg::*;
#(
    parameter int unsigned WORD_W      = 8,
    parameter int unsigned ABSENT_BITS = 512
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bclk_i,
    input  logic              tx_sync_i,
    input  logic              rx_sync_i,
    input  logic              rx_data_i,
    input  logic [WORD_W-1:0] tx_word_i,
    output logic              tx_data_o,
    output logic              tx_drive_o,
    output logic              tx_slot_n_o,
    output logic [WORD_W-1:0] rx_word_o,
    output logic              rx_valid_o,
    output logic              frame_long_o
);
    localparam int unsigned AW = $clog2(ABSENT_BITS + 1);
    localparam logic [AW-1:0] IDLE_LIMIT = AW'(ABSENT_BITS - 1);

    logic          rise, fall;
    logic [1:0]    sync_vec;
    width_res_t    res [2];
    frame_fmt_e    fmt_q;
    logic          tx_present;
    logic [AW-1:0] idle_cnt;

    pcm_edge_sense u_edges (
        .clk    (clk),
        .rst    (rst),
        .bclk_i (bclk_i),
        .rise_o (rise),
        .fall_o (fall)
    );

    // index 0: transmit sync, index 1: receive sync
    assign sync_vec = {rx_sync_i, tx_sync_i};

    for (genvar gi = 0; gi < 2; gi++) begin : g_meter
        pcm_width_meter u_meter (
            .clk    (clk),
            .rst    (rst),
            .sync_i (sync_vec[gi]),
            .fall_i (fall),
            .res_o  (res[gi])
        );
    end

    // Transmit sync presence: lost after ABSENT_BITS rising edges with it low
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_present <= 1'b0;
            idle_cnt   <= '0;
        end else if (tx_sync_i) begin
            tx_present <= 1'b1;
            idle_cnt   <= '0;
        end else if (rise && tx_present) begin
            if (idle_cnt == IDLE_LIMIT) tx_present <= 1'b0;
            else                        idle_cnt   <= idle_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                             fmt_q <= FMT_SHORT;
        else if (res[0].done)                fmt_q <= res[0].fmt;
        else if (res[1].done && !tx_present) fmt_q <= res[1].fmt;
    end

    pcm_tx_slot #(.WORD_W(WORD_W)) u_tx (
        .clk     (clk),
        .rst     (rst),
        .sync_i  (tx_sync_i),
        .bclk_i  (bclk_i),
        .rise_i  (rise),
        .fall_i  (fall),
        .fmt_i   (fmt_q),
        .word_i  (tx_word_i),
        .data_o  (tx_data_o),
        .drive_o (tx_drive_o)
    );

    pcm_rx_slot #(.WORD_W(WORD_W)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .sync_i  (rx_sync_i),
        .fall_i  (fall),
        .data_i  (rx_data_i),
        .fmt_i   (fmt_q),
        .word_o  (rx_word_o),
        .valid_o (rx_valid_o)
    );

    assign tx_slot_n_o  = ~tx_drive_o;
    assign frame_long_o = (fmt_q == FMT_LONG);

    p_fmt_changes_on_pulse_r1: assert property (@(posedge clk) disable iff (rst)
        !$stable(fmt_q) |-> $past(res[0].done || (res[1].done && !tx_present)));
    p_quiet_without_tx_sync_r9: assert property (@(posedge clk) disable iff (rst)
        !tx_present |-> !tx_drive_o);
    p_rx_ignored_when_tx_r9: assert property (@(posedge clk) disable iff (rst)
        tx_present && !res[0].done |=> $stable(fmt_q));
endmodule

// File: tb/tb_pcm_serial_port.sv
module tb_pcm_serial_port;
    localparam int HP = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bclk = 1'b0, tx_fs = 1'b0, rx_fs = 1'b0, rx_din = 1'b0;
    logic [7:0] tx_word = 8'h00;
    logic       tx_data, tx_drive, tx_slot_n, rx_valid, frame_long;
    logic [7:0] rx_word;

    int checks = 0, errors = 0;
    int vcount = 0;
    logic oe_h [32], d_h [32], oe_l [32];

    always #5 clk = ~clk;

    pcm_serial_port #(.WORD_W(8), .ABSENT_BITS(40)) dut (
        .clk(clk), .rst(rst), .bclk_i(bclk), .tx_sync_i(tx_fs), .rx_sync_i(rx_fs),
        .rx_data_i(rx_din), .tx_word_i(tx_word), .tx_data_o(tx_data),
        .tx_drive_o(tx_drive), .tx_slot_n_o(tx_slot_n), .rx_word_o(rx_word),
        .rx_valid_o(rx_valid), .frame_long_o(frame_long)
    );

    always @(posedge clk) if (rx_valid) vcount <= vcount + 1;

    task automatic check(input int act, input int exp, input string req, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // R8 checked in every sampled phase
    task automatic sample_slot();
        check(int'(tx_slot_n), int'(!tx_drive), "R8", "slot indicator vs drive");
        if (!tx_drive) check(int'(tx_data), 0, "R8", "data low while released");
    endtask

    task automatic run_frame(input int n, input int txl, input int rxl,
                             input logic [7:0] rbits, input int roff, input logic [7:0] tw);
        vcount  = 0;
        tx_word = tw;
        for (int p = 0; p < n; p++) begin
            @(negedge clk);
            bclk  = 1'b1;
            tx_fs = (p < txl);
            rx_fs = (p < rxl);
            if (p - roff >= 0 && p - roff < 8) rx_din = rbits[7 - (p - roff)];
            if (p == 2) tx_word = ~tw;
            repeat (HP) @(negedge clk);
            oe_h[p] = tx_drive;
            d_h[p]  = tx_data;
            sample_slot();
            bclk = 1'b0;
            repeat (HP) @(negedge clk);
            oe_l[p] = tx_drive;
            sample_slot();
        end
        tx_word = tw;
    endtask

    task automatic verify_tx(input bit lng, input int n, input int txl,
                             input logic [7:0] w, input string req);
        for (int p = 0; p < n; p++) begin
            int eh, el, ed;
            if (lng) begin
                eh = (p < ((txl > 8) ? txl : 8)) ? 1 : 0;
                el = (p < ((txl > 7) ? txl : 7)) ? 1 : 0;
                ed = (p < 8) ? int'(w[7 - p]) : int'(w[0]);
            end else begin
                eh = (p >= 1 && p <= 8) ? 1 : 0;
                el = (p >= 1 && p <= 7) ? 1 : 0;
                ed = (p >= 1 && p <= 8) ? int'(w[8 - p]) : 0;
            end
            check(int'(oe_h[p]), eh, req, $sformatf("drive high phase %0d", p));
            check(int'(oe_l[p]), el, req, $sformatf("drive low phase %0d", p));
            if (eh == 1) check(int'(d_h[p]), ed, req, $sformatf("data bit period %0d", p));
        end
    endtask

    task automatic verify_off(input int n, input string req);
        for (int p = 0; p < n; p++) begin
            check(int'(oe_h[p]), 0, req, $sformatf("drive off high %0d", p));
            check(int'(oe_l[p]), 0, req, $sformatf("drive off low %0d", p));
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        check(int'(tx_drive), 0, "R11", "drive in reset");
        check(int'(tx_slot_n), 1, "R11", "slot in reset");
        check(int'(rx_valid), 0, "R11", "valid in reset");
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(int'(tx_drive), 0, "R11", "drive after reset");
        check(int'(frame_long), 0, "R1", "format after reset");
    endtask

    task automatic t_short();
        run_frame(16, 1, 1, 8'h3C, 1, 8'hA5);
        verify_tx(1'b0, 16, 1, 8'hA5, "R5");
        check(int'(rx_word), 8'h3C, "R7", "short rx word");
        check(vcount, 1, "R10", "valid pulses short frame");
        check(int'(frame_long), 0, "R1", "one-period pulse keeps short");
    endtask

    task automatic t_long();
        run_frame(16, 3, 3, 8'h00, 0, 8'h00);
        check(int'(frame_long), 1, "R1", "three-period pulse selects long");
        run_frame(16, 3, 3, 8'hC9, 0, 8'h5A);
        verify_tx(1'b1, 16, 3, 8'h5A, "R2_R3");
        check(int'(rx_word), 8'hC9, "R6", "long rx word");
        check(vcount, 1, "R10", "valid pulses long frame");
    endtask

    task automatic t_long_hold();
        run_frame(16, 11, 3, 8'h81, 0, 8'h96);
        verify_tx(1'b1, 16, 11, 8'h96, "R4");
        check(int'(rx_word), 8'h81, "R6", "rx word with long tx sync");
    endtask

    task automatic t_tx_priority();
        run_frame(16, 3, 1, 8'h2B, 0, 8'h33);
        check(int'(frame_long), 1, "R9", "rx width ignored with tx sync");
        verify_tx(1'b1, 16, 3, 8'h33, "R3");
        check(int'(rx_word), 8'h2B, "R6", "rx long timing kept");
    endtask

    task automatic t_rx_only();
        for (int f = 0; f < 4; f++) begin
            run_frame(16, 0, 1, 8'h00, 1, 8'hFF);
            verify_off(16, "R9");
        end
        check(int'(frame_long), 0, "R9", "rx width decides when tx absent");
        run_frame(16, 0, 1, 8'h6E, 1, 8'hFF);
        verify_off(16, "R9");
        check(int'(rx_word), 8'h6E, "R7", "receive-only short word");
        check(vcount, 1, "R10", "valid pulses receive-only");
    endtask

    task automatic t_word_per_frame();
        run_frame(16, 1, 1, 8'hE1, 1, 8'h4C);
        verify_tx(1'b0, 16, 1, 8'h4C, "R10");
        check(int'(rx_word), 8'hE1, "R7", "rx word frame A");
        run_frame(16, 1, 1, 8'h1E, 1, 8'hB3);
        verify_tx(1'b0, 16, 1, 8'hB3, "R10");
        check(int'(rx_word), 8'h1E, "R7", "rx word frame B");
        check(int'(frame_long), 0, "R1", "short kept with tx back");
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_short();
                t_long();
                t_long_hold();
                t_tx_priority();
                t_rx_only();
                t_word_per_frame();
            end
            begin
                repeat (150000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule